// File: doc/BRIEF.md
# Tap-Timed DRAM Strobe Sequencer

This block produces the row strobe, the row/column address-select line, the column strobe and the write line for a bank of multiplexed-address dynamic RAM that sits behind an 8-bit processor bus. A fast sampling clock replaces an analog delay line. Each delay tap is a parameter counted in sampling-clock cycles from the start of an access.

An access starts when the bus shows a memory request and the external decode says the RAM is addressed. RAS falls first, while the address mux still presents the low address byte as the row. A few cycles later the mux swings to the high byte. CAS then falls. RAS is lifted again at a fixed point so that the RAM can precharge while CAS still holds the read data. CAS and the mux return to idle only when the processor drops its request. A refresh request runs a RAS-only cycle on the row address that the processor supplies. A write begins only once the write strobe is present, so the RAM write line is already settled when the strobes arrive.

All outputs are registered and active-low. The bus inputs are taken to be synchronous to the sampling clock. Default taps: mux at 2 cycles, CAS at 4, RAS release at 10, and a minimum RAS-high time of 4 cycles.

Top module: `dram_strobe_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, ras_n, cas_n, col_sel_n and ram_we_n are all 1.
- R2: When cpu_mreq_n=0, cpu_rd_n=0 and ram_hit=1 are sampled at a clock edge, ras_n is 0 after that edge. cpu_m1_n=0 with ram_hit=1 also starts a cycle, even while cpu_mreq_n=1.
- R3: col_sel_n (0 selects the high address byte, 1 the low byte) goes to 0 T_MUX edges after the edge at which ras_n fell.
- R4: cas_n goes to 0 T_CAS edges after the edge at which ras_n fell. cas_n is never 0 while col_sel_n is 1.
- R5: ras_n returns to 1 T_RAS edges after it fell. If the request is still held, cas_n stays 0 and col_sel_n stays 0.
- R6: The first edge at which cpu_mreq_n=1 and cpu_m1_n=1 are both sampled sets cas_n, col_sel_n and ram_we_n to 1.
- R7: With cpu_mreq_n=0, ram_hit=1 and both cpu_rd_n and cpu_wr_n at 1, no cycle starts. When cpu_wr_n goes to 0, ram_we_n and ras_n fall at the same edge. In a read cycle, ram_we_n stays 1.
- R8: cpu_rfsh_n=0 with cpu_mreq_n=0 and ram_hit=1 runs a cycle in which ras_n falls and rises at its taps, while cas_n and col_sel_n stay 1 throughout.
- R9: After ras_n rises, no new cycle starts until the request has been released and ras_n has been 1 for at least T_PRE cycles. A request held past the RAS release does not restart the cycle.
- R10: If the request is released before the RAS release tap, ras_n, cas_n, col_sel_n and ram_we_n all return to 1 at the next edge, and the precharge interval of R9 still applies.
- R11: With ram_hit=0, no strobe input starts a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock that stands in for the delay line |
| rst | input | 1 | Synchronous reset, active high |
| cpu_mreq_n | input | 1 | Processor memory request, active low |
| cpu_rd_n | input | 1 | Processor read strobe, active low |
| cpu_wr_n | input | 1 | Processor write strobe, active low |
| cpu_rfsh_n | input | 1 | Processor refresh indication, active low |
| cpu_m1_n | input | 1 | Processor opcode-fetch indication, active low |
| ram_hit | input | 1 | Decoded on-board RAM selection, active high |
| ras_n | output | 1 | Row address strobe, active low |
| col_sel_n | output | 1 | Address mux select: 0 high byte (column), 1 low byte (row) |
| cas_n | output | 1 | Column address strobe, active low |
| ram_we_n | output | 1 | RAM write line, active low |

## Verification
If the tap counter or the state held the wrong value, the first edge of ras_n, col_sel_n or cas_n after the request would move by one or more cycles. The bench locates each edge to the exact cycle, so such a fault shows up within the first ten cycles of an access. A lost refresh or write flag shows at once as a CAS pulse during refresh or as a write line that does not fall together with RAS. A precharge counter that is off appears as a restart one cycle too early or too late after an aborted access.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_HOLD} seq_state_t;
  typedef enum logic [1:0] {AC_READ, AC_WRITE, AC_REFRESH} acc_kind_t;
endpackage

// File: rtl/dseq_cycle_qual.sv
module dseq_cycle_qual
  import dseq_pkg::*;
(
  input  logic      mreq_n,
  input  logic      rd_n,
  input  logic      wr_n,
  input  logic      rfsh_n,
  input  logic      m1_n,
  input  logic      hit,
  output logic      start_req,
  output acc_kind_t kind,
  output logic      released
);
  logic any_strobe;

  always_comb begin
    any_strobe = !rd_n || !wr_n || !rfsh_n;
    start_req  = hit && ((!mreq_n && any_strobe) || !m1_n);
    released   = mreq_n && m1_n;
    if (!rfsh_n && !mreq_n)
      kind = AC_REFRESH;
    else if (!wr_n)
      kind = AC_WRITE;
    else
      kind = AC_READ;
  end
endmodule

// File: rtl/dseq_interval.sv
module dseq_interval #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= LIM;
    else if (restart)
      cnt <= ONE;
    else if (cnt < LIM)
      cnt <= cnt + ONE;
  end

  assign done = (cnt == LIM);

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt <= LIM);
  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !restart) |=> done);
endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
  import dseq_pkg::*;
#(
  parameter int T_MUX = 2,
  parameter int T_CAS = 4,
  parameter int T_RAS = 10,
  parameter int T_PRE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cpu_mreq_n,
  input  logic cpu_rd_n,
  input  logic cpu_wr_n,
  input  logic cpu_rfsh_n,
  input  logic cpu_m1_n,
  input  logic ram_hit,
  output logic ras_n,
  output logic col_sel_n,
  output logic cas_n,
  output logic ram_we_n
);
  localparam int CW = $clog2(T_RAS + 1);
  localparam logic [CW-1:0] TAP_MUX = CW'(T_MUX);
  localparam logic [CW-1:0] TAP_CAS = CW'(T_CAS);
  localparam logic [CW-1:0] TAP_RAS = CW'(T_RAS);
  localparam logic [CW-1:0] C_ONE   = CW'(1);

  seq_state_t    state;
  acc_kind_t     kind_q;
  acc_kind_t     kind_now;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nx;
  logic          start_req;
  logic          released;
  logic          pre_done;
  logic          ras_rise;

  dseq_cycle_qual u_qual (
    .mreq_n    (cpu_mreq_n),
    .rd_n      (cpu_rd_n),
    .wr_n      (cpu_wr_n),
    .rfsh_n    (cpu_rfsh_n),
    .m1_n      (cpu_m1_n),
    .hit       (ram_hit),
    .start_req (start_req),
    .kind      (kind_now),
    .released  (released)
  );

  dseq_interval #(.LIMIT(T_PRE)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (ras_rise),
    .done    (pre_done)
  );

  assign cnt_nx   = cnt + C_ONE;
  assign ras_rise = (state == SQ_RUN) && (released || cnt_nx == TAP_RAS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      kind_q    <= AC_READ;
      cnt       <= '0;
      ras_n     <= 1'b1;
      col_sel_n <= 1'b1;
      cas_n     <= 1'b1;
      ram_we_n  <= 1'b1;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (start_req && pre_done) begin
            state    <= SQ_RUN;
            kind_q   <= kind_now;
            cnt      <= '0;
            ras_n    <= 1'b0;
            ram_we_n <= (kind_now != AC_WRITE);
          end
        end
        SQ_RUN: begin
          if (released) begin
            state     <= SQ_IDLE;
            ras_n     <= 1'b1;
            col_sel_n <= 1'b1;
            cas_n     <= 1'b1;
            ram_we_n  <= 1'b1;
          end else begin
            cnt <= cnt_nx;
            if (cnt_nx == TAP_MUX && kind_q != AC_REFRESH)
              col_sel_n <= 1'b0;
            if (cnt_nx == TAP_CAS && kind_q != AC_REFRESH)
              cas_n <= 1'b0;
            if (cnt_nx == TAP_RAS) begin
              ras_n <= 1'b1;
              state <= SQ_HOLD;
            end
          end
        end
        SQ_HOLD: begin
          if (released) begin
            state     <= SQ_IDLE;
            col_sel_n <= 1'b1;
            cas_n     <= 1'b1;
            ram_we_n  <= 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R4
  cas_after_col_chk: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !col_sel_n);
  // R5
  cas_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cas_n && !released) |=> !cas_n);
  // R6
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_HOLD && released) |=> (cas_n && col_sel_n && ram_we_n));
  // R7
  we_with_ras_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ram_we_n) |-> $fell(ras_n));
  // R8
  refresh_no_cas_chk: assert property (@(posedge clk) disable iff (rst)
    (state != SQ_IDLE && kind_q == AC_REFRESH) |-> (cas_n && col_sel_n));
  // R9
  ras_precharge_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> $past(pre_done));
endmodule

// File: tb/test_dram_strobe_seq.sv
module test_dram_strobe_seq;
  localparam int P_MUX = 2;
  localparam int P_CAS = 4;
  localparam int P_RAS = 10;
  localparam int P_PRE = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_mreq_n = 1'b1, cpu_rd_n = 1'b1, cpu_wr_n = 1'b1;
  logic cpu_rfsh_n = 1'b1, cpu_m1_n = 1'b1, ram_hit = 1'b0;
  logic ras_n, col_sel_n, cas_n, ram_we_n;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  dram_strobe_seq #(.T_MUX(P_MUX), .T_CAS(P_CAS), .T_RAS(P_RAS), .T_PRE(P_PRE)) i_dram_strobe_seq (
    .clk(clk), .rst(rst),
    .cpu_mreq_n(cpu_mreq_n), .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n),
    .cpu_rfsh_n(cpu_rfsh_n), .cpu_m1_n(cpu_m1_n), .ram_hit(ram_hit),
    .ras_n(ras_n), .col_sel_n(col_sel_n), .cas_n(cas_n), .ram_we_n(ram_we_n)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_idle(input int n);
    cpu_mreq_n = 1'b1; cpu_rd_n = 1'b1; cpu_wr_n = 1'b1;
    cpu_rfsh_n = 1'b1; cpu_m1_n = 1'b1; ram_hit = 1'b0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic measure(input int n, output int ras_f, output int col_f,
                         output int cas_f, output int ras_r);
    ras_f = -1; col_f = -1; cas_f = -1; ras_r = -1;
    for (int i = 1; i <= n; i++) begin
      tick();
      if (ras_f < 0 && !ras_n) ras_f = i;
      if (col_f < 0 && !col_sel_n) col_f = i;
      if (cas_f < 0 && !cas_n) cas_f = i;
      if (ras_f >= 0 && ras_r < 0 && ras_n) ras_r = i;
    end
  endtask

  task automatic t_reset();
    chk({ras_n, cas_n, col_sel_n, ram_we_n} == 4'hF, "R1 in reset", {ras_n, cas_n, col_sel_n, ram_we_n}, 15);
    rst = 1'b0;
    tick();
    chk({ras_n, cas_n, col_sel_n, ram_we_n} == 4'hF, "R1 after reset", {ras_n, cas_n, col_sel_n, ram_we_n}, 15);
  endtask

  task automatic t_read();
    int rf, cf, sf, rr;
    ram_hit = 1'b1; cpu_mreq_n = 1'b0; cpu_rd_n = 1'b0;
    measure(14, rf, cf, sf, rr);
    chk(rf == 1, "R2 read ras fall", rf, 1);
    chk(cf == 1 + P_MUX, "R3 mux tap", cf, 1 + P_MUX);
    chk(sf == 1 + P_CAS, "R4 cas tap", sf, 1 + P_CAS);
    chk(rr == 1 + P_RAS, "R5 ras release tap", rr, 1 + P_RAS);
    chk(cas_n == 1'b0 && col_sel_n == 1'b0, "R5 cas held", {cas_n, col_sel_n}, 0);
    chk(ras_n == 1'b1, "R9 no restart while held", ras_n, 1);
    chk(ram_we_n == 1'b1, "R7 read keeps we high", ram_we_n, 1);
    cpu_mreq_n = 1'b1; cpu_rd_n = 1'b1;
    tick();
    chk({cas_n, col_sel_n, ram_we_n} == 3'b111, "R6 release", {cas_n, col_sel_n, ram_we_n}, 7);
    bus_idle(6);
  endtask

  task automatic t_write();
    int rf, cf, sf, rr;
    ram_hit = 1'b1; cpu_mreq_n = 1'b0;
    measure(3, rf, cf, sf, rr);
    chk(rf == -1, "R7 no start before write strobe", rf, -1);
    cpu_wr_n = 1'b0;
    tick();
    chk(ras_n == 1'b0 && ram_we_n == 1'b0, "R7 we with ras", {ras_n, ram_we_n}, 0);
    measure(12, rf, cf, sf, rr);
    chk(ram_we_n == 1'b0 && cas_n == 1'b0, "R7 we held", {ram_we_n, cas_n}, 0);
    cpu_mreq_n = 1'b1; cpu_wr_n = 1'b1;
    tick();
    chk({cas_n, col_sel_n, ram_we_n} == 3'b111, "R6 write release", {cas_n, col_sel_n, ram_we_n}, 7);
    bus_idle(6);
  endtask

  task automatic t_refresh();
    int rf, cf, sf, rr;
    ram_hit = 1'b1; cpu_mreq_n = 1'b0; cpu_rfsh_n = 1'b0;
    measure(14, rf, cf, sf, rr);
    chk(rf == 1, "R8 refresh ras fall", rf, 1);
    chk(rr == 1 + P_RAS, "R8 refresh ras rise", rr, 1 + P_RAS);
    chk(cf == -1 && sf == -1, "R8 no mux or cas", cf + sf, -2);
    bus_idle(6);
  endtask

  task automatic t_no_hit();
    int rf, cf, sf, rr;
    ram_hit = 1'b0; cpu_mreq_n = 1'b0; cpu_rd_n = 1'b0; cpu_m1_n = 1'b0;
    measure(5, rf, cf, sf, rr);
    chk(rf == -1, "R11 no hit no cycle", rf, -1);
    bus_idle(2);
  endtask

  task automatic t_opfetch();
    int rf, cf, sf, rr;
    ram_hit = 1'b1; cpu_m1_n = 1'b0;
    measure(6, rf, cf, sf, rr);
    chk(rf == 1, "R2 opcode fetch start", rf, 1);
    chk(sf == 1 + P_CAS, "R4 opcode fetch cas", sf, 1 + P_CAS);
    cpu_m1_n = 1'b1;
    tick();
    chk({ras_n, cas_n, col_sel_n} == 3'b111, "R10 fetch early end", {ras_n, cas_n, col_sel_n}, 7);
    bus_idle(6);
  endtask

  task automatic t_early();
    int rf, cf, sf, rr;
    ram_hit = 1'b1; cpu_mreq_n = 1'b0; cpu_wr_n = 1'b0;
    measure(2, rf, cf, sf, rr);
    chk(rf == 1 && ram_we_n == 1'b0, "R7 early write start", rf, 1);
    cpu_mreq_n = 1'b1; cpu_wr_n = 1'b1;
    tick();
    chk({ras_n, cas_n, col_sel_n, ram_we_n} == 4'hF, "R10 abort", {ras_n, cas_n, col_sel_n, ram_we_n}, 15);
    cpu_mreq_n = 1'b0; cpu_rd_n = 1'b0;
    measure(8, rf, cf, sf, rr);
    chk(rf == P_PRE, "R9 precharge gap", rf, P_PRE);
    bus_idle(14);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    tick();
    tick();
    t_reset();
    bus_idle(6);
    t_read();
    t_write();
    t_refresh();
    t_no_hit();
    t_opfetch();
    t_early();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule